// File: doc/BRIEF.md
# I/O String Fault Adjudicator

This block judges the completion codes that the four members of a redundant computing set report at an I/O-completion sync point. Every member, this unit ("self") and three peers, reports either a clean completion or a completion that saw an error on one of four sensor strings. Synchronization has already been confirmed, and the codes have already been gathered. The block looks at what the codes say. It decides whether a common string fault explains the errors or whether a single member's receiver has failed.

There are four possible outcomes:
- All data is used.
- One string is taken out of filtering for the rest of the current sensor.
- One peer is flagged as out of sync.
- This unit itself retires from the set.

Any pattern that the one-failure-at-a-time assumption does not cover is reported as unexpected and changes nothing. The record of excluded strings is sticky. It is cleared when the user starts a new sensor.

The control is a two-state machine:
- **ACTIVE** is the state after reset. Evaluations are judged and applied in this state.
- **RETIRED** is entered by the transition *self-fault*, which is an evaluation where only this unit reports an error. In this state evaluations are acknowledged but have no effect. The only way out is reset.

Top module: `string_fault_adjudicator`

## Requirements
- R1: Each code is 3 bits. Code 011 means a clean completion, and code 1ss means an error on string ss+1, which is bit ss of the use mask. After reset, the use mask is 1111, no flag is set and the unit is not retired.
- R2: `res_valid_o` is high in exactly the cycle that follows a cycle with `eval_i` high, and it is low otherwise.
- R3: When all four codes are 011, no peer flag and no unexpected flag is raised, and the use mask is unchanged.
- R4: When all four codes are the same error code 1ss, mask bit ss clears one cycle after the strobe. It stays cleared until a sensor start or a reset.
- R5: When self reports 011, one peer reports an error code and the other two report 011, the flag bit of that peer is set for one result cycle, and the mask is unchanged. Peer i occupies `peer_codes_i[3i+2:3i]` and flag bit i.
- R6: When self reports an error code and all three peers report 011, the unit enters RETIRED. `retired_o` stays high until reset.
- R7: Every other combination sets `unexpected_o` for one result cycle and changes neither the mask nor the state. This includes codes 000 to 010, errors on two or more members that do not all agree, and different error strings.
- R8: A `sensor_start_i` strobe makes the mask 1111 one cycle later. If an eviction is judged in the same cycle, it is applied on top of the cleared record.
- R9: In RETIRED, an evaluation still gives `res_valid_o`, but it raises no flag and evicts nothing. A sensor start still clears the mask.
- R10: Evictions of different strings accumulate in the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_i | input | 1 | Strobe: judge the codes presented this cycle |
| sensor_start_i | input | 1 | Strobe: a new sensor begins, so clear the exclusion record |
| self_code_i | input | 3 | Completion code of this unit |
| peer_codes_i | input | 9 | Completion codes of peers 0 to 2, 3 bits each |
| res_valid_o | output | 1 | A result is presented this cycle |
| peer_fail_o | output | 3 | Per-peer out-of-sync flag, valid with res_valid_o |
| unexpected_o | output | 1 | The judged pattern is outside the defined set |
| use_mask_o | output | 4 | Strings still used in filtering, one bit per string |
| retired_o | output | 1 | This unit has left the redundant set |

## Verification
The bench applies several kinds of input pattern:
- Unanimous clean codes, which must leave everything untouched.
- Unanimous equal error codes on each string, which separate a string fault from a receiver fault and show that exclusions accumulate.
- A single erring peer in each slot, which shows that the blame lands on the correct peer and not on a string.
- A lone erring self, which shows that the unit retires.

Mixed error strings, double errors and non-completion codes check that every undefined case is reported and changes nothing. Sensor starts, given alone and together with an eviction, and evaluations while retired, cover the sticky record and the terminal state. A behavioural model of the block is compared with every output on every clock.

// File: rtl/adj_pkg.sv
package adj_pkg;

    // Outcome of judging one set of completion codes
    typedef enum logic [2:0] {
        V_USE_ALL = 3'd0,
        V_EVICT   = 3'd1,
        V_PEER    = 3'd2,
        V_SELF    = 3'd3,
        V_ODD     = 3'd4
    } verdict_e;

    // Control state of the adjudicator
    typedef enum logic {
        ST_ACTIVE  = 1'b0,
        ST_RETIRED = 1'b1
    } state_e;

endpackage

// File: rtl/adj_classify.sv
module adj_classify
    import adj_pkg::*;
#(
    parameter int NUM_PEERS = 3,
    parameter int CODE_W    = 3
) (
    input  logic [CODE_W-1:0]           self_code,
    input  logic [NUM_PEERS*CODE_W-1:0] peer_codes,
    output verdict_e                    verdict,
    output logic [CODE_W-2:0]           str_idx,
    output logic [NUM_PEERS-1:0]        peer_sel
);

    localparam int          SIDX_W = CODE_W - 1;
    localparam logic [CODE_W-1:0] CLEAN = {1'b0, {SIDX_W{1'b1}}};

    logic [NUM_PEERS-1:0] peer_clean;
    logic [NUM_PEERS-1:0] peer_err;
    logic [NUM_PEERS-1:0] peer_same;
    logic                 self_clean;
    logic                 self_err;

    // One decoder for each peer slot
    genvar gi;
    generate
        for (gi = 0; gi < NUM_PEERS; gi++) begin : g_peer
            logic [CODE_W-1:0] code;
            assign code           = peer_codes[gi*CODE_W +: CODE_W];
            assign peer_clean[gi] = (code == CLEAN);
            assign peer_err[gi]   = code[CODE_W-1];
            assign peer_same[gi]  = (code == self_code);
        end
    endgenerate

    assign self_clean = (self_code == CLEAN);
    assign self_err   = self_code[CODE_W-1];
    assign str_idx    = self_code[SIDX_W-1:0];

    always_comb begin
        verdict  = V_ODD;
        peer_sel = '0;
        if (self_clean && (&peer_clean)) begin
            verdict = V_USE_ALL;
        end else if (self_err && (&peer_same)) begin
            verdict = V_EVICT;
        end else if (self_clean && $onehot(peer_err) && (&(peer_clean | peer_err))) begin
            verdict  = V_PEER;
            peer_sel = peer_err;
        end else if (self_err && (&peer_clean)) begin
            verdict = V_SELF;
        end
    end

endmodule

// File: rtl/adj_record.sv
module adj_record #(
    parameter int NUM_STRINGS = 4,
    localparam int IDX_W      = $clog2(NUM_STRINGS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   evict,
    input  logic [IDX_W-1:0]       evict_idx,
    output logic [NUM_STRINGS-1:0] use_mask
);

    logic [NUM_STRINGS-1:0] excluded;
    logic [NUM_STRINGS-1:0] hit;

    // One decoder bit for each string
    genvar gk;
    generate
        for (gk = 0; gk < NUM_STRINGS; gk++) begin : g_str
            assign hit[gk] = evict && (evict_idx == IDX_W'(gk));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            excluded <= '0;
        end else begin
            excluded <= (clear ? '0 : excluded) | hit;
        end
    end

    assign use_mask = ~excluded;

    // R4: without a clear, a string once dropped never returns
    a_r4_mask_only_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((use_mask & ~$past(use_mask)) == '0));

    // R8: a clear with no eviction restores every string
    a_r8_clear_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !evict) |=> (&use_mask));

endmodule

// File: rtl/string_fault_adjudicator.sv
module string_fault_adjudicator
    import adj_pkg::*;
#(
    parameter int NUM_PEERS = 3,
    parameter int CODE_W    = 3,
    localparam int NUM_STRINGS = 1 << (CODE_W - 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           eval_i,
    input  logic                           sensor_start_i,
    input  logic [CODE_W-1:0]              self_code_i,
    input  logic [NUM_PEERS*CODE_W-1:0]    peer_codes_i,
    output logic                           res_valid_o,
    output logic [NUM_PEERS-1:0]           peer_fail_o,
    output logic                           unexpected_o,
    output logic [NUM_STRINGS-1:0]         use_mask_o,
    output logic                           retired_o
);

    verdict_e             verdict;
    logic [CODE_W-2:0]    str_idx;
    logic [NUM_PEERS-1:0] peer_sel;
    state_e               state_q;
    state_e               state_d;
    logic                 judge;
    logic                 do_evict;

    adj_classify #(
        .NUM_PEERS (NUM_PEERS),
        .CODE_W    (CODE_W)
    ) u_classify (
        .self_code  (self_code_i),
        .peer_codes (peer_codes_i),
        .verdict    (verdict),
        .str_idx    (str_idx),
        .peer_sel   (peer_sel)
    );

    // Only an active unit acts on what it judges
    assign judge    = eval_i && (state_q == ST_ACTIVE);
    assign do_evict = judge && (verdict == V_EVICT);

    adj_record #(
        .NUM_STRINGS (NUM_STRINGS)
    ) u_record (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (sensor_start_i),
        .evict     (do_evict),
        .evict_idx (str_idx),
        .use_mask  (use_mask_o)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE:  if (eval_i && (verdict == V_SELF)) state_d = ST_RETIRED;
            ST_RETIRED: state_d = ST_RETIRED;
            default:    state_d = ST_ACTIVE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ACTIVE;
        else        state_q <= state_d;
    end

    // Registered result outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_o  <= 1'b0;
            peer_fail_o  <= '0;
            unexpected_o <= 1'b0;
        end else begin
            res_valid_o  <= eval_i;
            peer_fail_o  <= (judge && (verdict == V_PEER)) ? peer_sel : '0;
            unexpected_o <= judge && (verdict == V_ODD);
        end
    end

    assign retired_o = (state_q == ST_RETIRED);

    // R2: a result follows every strobe
    a_r2_valid_after_eval: assert property (@(posedge clk) disable iff (!rst_n)
        eval_i |=> res_valid_o);

    // R2: no result without a strobe
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_i |=> !res_valid_o);

    // R5: at most one peer is blamed at a time
    a_r5_single_peer: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(peer_fail_o));

    // R6: retirement lasts until reset
    a_r6_retired_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        retired_o |=> retired_o);

    // R7: an unexpected pattern leaves the mask alone
    a_r7_odd_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && (verdict == V_ODD) && !sensor_start_i) |=> $stable(use_mask_o));

    // R9: a retired unit raises no flags
    a_r9_retired_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (retired_o && eval_i) |=> ((peer_fail_o == '0) && !unexpected_o));

endmodule

// File: tb/tb_string_fault_adjudicator.sv
module tb_string_fault_adjudicator;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       eval_i = 1'b0;
    logic       sensor_start_i = 1'b0;
    logic [2:0] self_code_i = 3'b011;
    logic [8:0] peer_codes_i = 9'b011011011;
    logic       res_valid_o;
    logic [2:0] peer_fail_o;
    logic       unexpected_o;
    logic [3:0] use_mask_o;
    logic       retired_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // model state
    logic [3:0] m_mask;
    logic       m_ret;
    logic       m_valid;
    logic [2:0] m_pf;
    logic       m_odd;

    string_fault_adjudicator dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .eval_i         (eval_i),
        .sensor_start_i (sensor_start_i),
        .self_code_i    (self_code_i),
        .peer_codes_i   (peer_codes_i),
        .res_valid_o    (res_valid_o),
        .peer_fail_o    (peer_fail_o),
        .unexpected_o   (unexpected_o),
        .use_mask_o     (use_mask_o),
        .retired_o      (retired_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected at most %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "res_valid", int'(res_valid_o), int'(m_valid));
        chk(tag, "peer_fail", int'(peer_fail_o), int'(m_pf));
        chk(tag, "unexpected", int'(unexpected_o), int'(m_odd));
        chk(tag, "use_mask", int'(use_mask_o), int'(m_mask));
        chk(tag, "retired", int'(retired_o), int'(m_ret));
    endtask

    // Behavioural judgement of one set of codes, counted by category
    task automatic model_step(input bit ev, input bit st, input int s, input int p0,
                              input int p1, input int p2);
        int pc[3];
        int n_clean;
        int n_err;
        int n_same;
        int err_slot;
        logic [3:0] mask_next;
        pc[0] = p0; pc[1] = p1; pc[2] = p2;
        n_clean = 0; n_err = 0; n_same = 0; err_slot = -1;
        for (int i = 0; i < 3; i++) begin
            if (pc[i] == 3) n_clean++;
            if (pc[i] >= 4) begin n_err++; err_slot = i; end
            if (pc[i] == s) n_same++;
        end
        mask_next = st ? 4'b1111 : m_mask;
        m_valid = ev;
        m_pf = 3'b000;
        m_odd = 1'b0;
        if (ev && !m_ret) begin
            if (s == 3 && n_clean == 3) begin
                // all data used
            end else if (s >= 4 && n_same == 3) begin
                mask_next[s-4] = 1'b0;
            end else if (s == 3 && n_clean == 2 && n_err == 1) begin
                m_pf[err_slot] = 1'b1;
            end else if (s >= 4 && n_clean == 3) begin
                m_ret = 1'b1;
            end else begin
                m_odd = 1'b1;
            end
        end
        m_mask = mask_next;
    endtask

    task automatic step(input string tag, input bit ev, input bit st, input int s,
                        input int p0, input int p1, input int p2);
        eval_i = ev;
        sensor_start_i = st;
        self_code_i = 3'(s);
        peer_codes_i = {3'(p2), 3'(p1), 3'(p0)};
        model_step(ev, st, s, p0, p1, p2);
        @(negedge clk);
        eval_i = 1'b0;
        sensor_start_i = 1'b0;
        compare_all(tag);
    endtask

    task automatic do_reset(input string tag);
        rst_n = 1'b0;
        eval_i = 1'b0;
        sensor_start_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_mask = 4'b1111; m_ret = 1'b0; m_valid = 1'b0; m_pf = 3'b000; m_odd = 1'b0;
        compare_all(tag);
    endtask

    initial begin
        @(negedge clk);
        do_reset("R1");
        step("R2", 0, 0, 3, 3, 3, 3);
        step("R3", 1, 0, 3, 3, 3, 3);
        step("R4", 1, 0, 6, 6, 6, 6);          // string 3 evicted -> 1011
        step("R4", 1, 0, 3, 3, 3, 3);          // exclusion persists
        step("R5", 1, 0, 3, 3, 5, 3);          // peer 1 blamed
        step("R5", 1, 0, 3, 4, 3, 3);          // peer 0 blamed
        step("R5", 1, 0, 3, 3, 3, 7);          // peer 2 blamed
        step("R7", 1, 0, 3, 4, 5, 3);          // two peers erring
        step("R7", 1, 0, 4, 4, 4, 5);          // mixed strings
        step("R7", 1, 0, 1, 1, 1, 1);          // programmed-sync code
        step("R7", 1, 0, 4, 3, 4, 3);          // self and one peer
        step("R10", 1, 0, 4, 4, 4, 4);         // string 1 too -> 1010
        step("R8", 0, 1, 3, 3, 3, 3);          // clear -> 1111
        step("R8", 1, 1, 7, 7, 7, 7);          // clear plus evict -> 0111
        step("R6", 1, 0, 5, 3, 3, 3);          // self retires
        step("R9", 1, 0, 5, 5, 5, 5);          // no eviction while retired
        step("R9", 1, 0, 3, 6, 3, 3);          // no peer flag while retired
        step("R9", 0, 1, 3, 3, 3, 3);          // clear still works
        step("R6", 0, 0, 3, 3, 3, 3);
        do_reset("R1");

        for (int n = 0; n < 800; n++) begin
            int kind;
            int s;
            int p[3];
            bit st;
            bit ev;
            kind = int'($urandom_range(0, 9));
            ev = ($urandom_range(0, 4) != 0);
            st = ($urandom_range(0, 11) == 0);
            s = 3; p[0] = 3; p[1] = 3; p[2] = 3;
            case (kind)
                0, 1: ;
                2, 3: begin
                    s = int'($urandom_range(4, 7));
                    p[0] = s; p[1] = s; p[2] = s;
                end
                4, 5: p[int'($urandom_range(0, 2))] = int'($urandom_range(4, 7));
                6: if ($urandom_range(0, 3) == 0) s = int'($urandom_range(4, 7));
                default: begin
                    s = int'($urandom_range(0, 7));
                    for (int i = 0; i < 3; i++) p[i] = int'($urandom_range(0, 7));
                end
            endcase
            step("RND", ev, st, s, p[0], p[1], p[2]);
            if ((n % 100) == 99) do_reset("R1");
        end
        finish_run();
    end

endmodule